// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus (I2C style) that fronts a byte-wide memory array held in on-chip registers. It runs on the system clock and oversamples the bus clock and bus data lines. It finds START and STOP conditions and frames bytes. It acknowledges a device address byte only when that byte carries the fixed family code and the three strap inputs. After that it either takes a memory address and data bytes, or streams bytes back to the master. The data line is open-drain: the block has one output enable that pulls the line low and never drives it high.

The array holds `2**ADDR_W` bytes. A full-size build sets `ADDR_W = 14` for 16,384 bytes. The default is smaller to keep elaboration light. Writes land in the array during the acknowledge of each data byte, so no busy period follows a write and the device is addressable again as soon as the STOP arrives. A level-sensitive protect input blocks every array write. Reads do not depend on it.

Top module: `fram_i2c_slave`

## Requirements
- R1: After reset the data-line pull-down `sda_oe_o` is released (0) and the slave ignores bus activity until it sees a START.
- R2: The device byte is `1010` in bits 7..4, the strap value in bits 3..1, and read/not-write in bit 0. When bits 7..1 match, the slave pulls SDA low on the ninth clock. On any mismatch SDA stays released for that clock and for every later clock until the next START, so the bytes that follow change nothing.
- R3: In a write, the device byte is followed by an upper and a lower address byte. The address is the low `ADDR_W` bits of {upper, lower}, and higher bits are ignored. Every following data byte is stored at the current address. Each of these bytes is acknowledged.
- R4: The current address goes up by one after every data byte written or loaded for reading, and wraps from `2**ADDR_W-1` to 0.
- R5: A repeated START with the read bit set returns bytes MSB first, starting at the current address. Each master ACK (SDA low on the ninth clock) continues the sequence. A master NACK ends it, and the slave keeps SDA released until the next START.
- R6: While `wp_i` is 1, data bytes are still acknowledged but the array is not changed. Reads return stored data whatever the level of `wp_i`.
- R7: A START with a matching device byte issued right after the STOP of a write is acknowledged. No busy or polling phase exists.
- R8: `sda_oe_o` only ever pulls low. It changes only while SCL is low, after a falling SCL edge, and SDA is sampled on rising SCL edges.
- R9: A device byte with the read bit set, sent without a preceding address, returns data from the current address left by the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND with all drivers) |
| strap_i | input | 3 | Device select strap levels compared with device byte bits 3..1 |
| wp_i | input | 1 | Write protect, 1 blocks every array write |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench tries every strap setting against every device code. A slave that compares the wrong bits, or acknowledges out of turn, loses or gains an acknowledge somewhere in that grid. A write that starts near the top of the array wraps to zero, and a read of more bytes than the array holds wraps a second time. A design with a bad increment or bad wrap returns bytes out of place. Data written with protect high is read back, with protect still high, as the old contents. A transaction with a mismatched device byte is followed by a readback that would show any leaked write. The bench also checks the current-address read and the acknowledge right after a STOP, and it watches for any enable change while SCL is high.

// File: rtl/fram_pkg.sv
package fram_pkg;

    localparam logic [3:0] DEV_FAMILY = 4'b1010;
    localparam logic [3:0] BIT_ACK    = 4'd8;   // rise count after eight data bits
    localparam logic [3:0] BIT_DONE   = 4'd9;   // rise count after the ninth clock

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WDAT,
        PH_RDAT
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_FAMILY) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/fram_bus_cond.sv
module fram_bus_cond
    import fram_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic                   scl_d;
    logic                   sda_d;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_q[SYNC_STAGES-1];
    assign sda_s = sda_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.sda   = sda_s;
        ev.scl   = scl_s;
    end

endmodule

// File: rtl/fram_proto.sv
module fram_proto
    import fram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        strap,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              sda_oe
);

    phase_e     phase;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic [7:0] hi;
    logic [7:0] rbuf;
    logic       mack;
    logic [2:0] bidx;

    always_comb bidx = 3'(4'd7 - cnt);

    always_ff @(posedge clk) begin
        wr_req <= 1'b0;
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            sh      <= '0;
            hi      <= '0;
            rbuf    <= '0;
            mack    <= 1'b0;
            addr    <= '0;
            wr_addr <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else if (ev.start) begin
            phase  <= PH_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
        end else if (phase != PH_IDLE) begin
            if (ev.rise) begin
                if (cnt < BIT_ACK) sh <= {sh[6:0], ev.sda};
                else               mack <= ~ev.sda;
                if (cnt != BIT_DONE) cnt <= cnt + 4'd1;
            end else if (ev.fall) begin
                if (cnt == BIT_ACK) begin
                    unique case (phase)
                        PH_DEV: begin
                            if (dev_hit(sh, strap)) sda_oe <= 1'b1;
                            else                    phase  <= PH_IDLE;
                        end
                        PH_AHI: begin
                            hi     <= sh;
                            sda_oe <= 1'b1;
                        end
                        PH_ALO: begin
                            addr   <= ADDR_W'({hi, sh});
                            sda_oe <= 1'b1;
                        end
                        PH_WDAT: begin
                            wr_req  <= 1'b1;
                            wr_addr <= addr;
                            wr_data <= sh;
                            addr    <= addr + 1'b1;
                            sda_oe  <= 1'b1;
                        end
                        PH_RDAT: sda_oe <= 1'b0;
                        default: ;
                    endcase
                end else if (cnt == BIT_DONE) begin
                    cnt <= '0;
                    unique case (phase)
                        PH_DEV: begin
                            if (sh[0]) begin
                                phase  <= PH_RDAT;
                                rbuf   <= rd_data;
                                addr   <= addr + 1'b1;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                phase  <= PH_AHI;
                                sda_oe <= 1'b0;
                            end
                        end
                        PH_AHI: begin
                            phase  <= PH_ALO;
                            sda_oe <= 1'b0;
                        end
                        PH_ALO: begin
                            phase  <= PH_WDAT;
                            sda_oe <= 1'b0;
                        end
                        PH_WDAT: sda_oe <= 1'b0;
                        PH_RDAT: begin
                            if (mack) begin
                                rbuf   <= rd_data;
                                addr   <= addr + 1'b1;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                phase  <= PH_IDLE;
                                sda_oe <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end else if (phase == PH_RDAT && cnt != 4'd0) begin
                    sda_oe <= ~rbuf[bidx];
                end
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_oe); // R2
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl); // R8
    AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> (addr == ADDR_W'(wr_addr + 1'b1))); // R4

endmodule

// File: rtl/fram_store.sv
module fram_store #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_i,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic [7:0] cur_w;

    assign rd_data = mem[rd_addr];
    assign cur_w   = mem[wr_addr];

    always_ff @(posedge clk) begin
        if (wr_req && !wp_i) mem[wr_addr] <= wr_data;
    end

    AST_WP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wp_i && wr_req) |=> (mem[$past(wr_addr)] == $past(cur_w))); // R6
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (!wp_i && wr_req) |=> (mem[$past(wr_addr)] == $past(wr_data))); // R3

endmodule

// File: rtl/fram_i2c_slave.sv
module fram_i2c_slave
    import fram_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);

    bus_ev_t           ev;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;
    logic              wr_req;

    fram_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    fram_proto #(.ADDR_W(ADDR_W)) u_proto (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .strap   (strap_i),
        .rd_data (rd_data),
        .addr    (cur_addr),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sda_oe  (sda_oe_o)
    );

    fram_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wp_i    (wp_i),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (cur_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/tb_fram_i2c_slave.sv
`timescale 1ns/1ps
module tb_fram_i2c_slave;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int Q     = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       wp = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    logic [7:0] exp_mem [DEPTH];
    int checks = 0;
    int errors = 0;
    int r8_bad = 0;
    logic prev_oe = 1'b0;
    bit   done = 1'b0;

    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    fram_i2c_slave #(.ADDR_W(AW)) dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    // R8: enable must not move while SCL is high
    always @(negedge clk) begin
        if (!rst && (sda_oe !== prev_oe) && m_scl) r8_bad++;
        prev_oe <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2 * Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] devb(input logic [2:0] code, input bit rd);
        return {4'b1010, code, rd};
    endfunction

    // set address, repeated START, read n bytes and compare with the model
    task automatic read_check(input logic [7:0] ahi, input logic [7:0] alo, input int n, input string req);
        bit ack;
        logic [7:0] got;
        int a;
        a = int'(alo) % DEPTH;
        bus_start();
        send_byte(devb(strap, 1'b0), ack);
        send_byte(ahi, ack);
        send_byte(alo, ack);
        bus_start();
        send_byte(devb(strap, 1'b1), ack);
        chk(ack, req, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, got);
            chk(got == exp_mem[(a + k) % DEPTH], req, got, exp_mem[(a + k) % DEPTH]);
        end
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] got;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
        tick(4);
        rst = 1'b0;
        tick(2);
        chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

        // R2: every strap against every device code, plus a wrong family
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            tick(2);
            for (int c = 0; c < 8; c++) begin
                bus_start();
                send_byte(devb(3'(c), 1'b0), ack);
                chk(ack == (s == c), "R2 device match", ack, (s == c));
                bus_stop();
            end
        end
        strap = 3'b101;
        bus_start();
        send_byte({4'b1011, strap, 1'b0}, ack);
        chk(!ack, "R2 wrong family", ack, 0);
        bus_stop();

        // R3/R4: fill whole array starting at 0x3A, upper address bits set
        bus_start();
        send_byte(devb(strap, 1'b0), ack);
        chk(ack, "R2 write device", ack, 1);
        send_byte(8'hFF, ack);
        chk(ack, "R3 addr hi ack", ack, 1);
        send_byte(8'hFA, ack);
        chk(ack, "R3 addr lo ack", ack, 1);
        for (int i = 0; i < DEPTH; i++) begin
            send_byte(pat(i), ack);
            exp_mem[(8'h3A + i) % DEPTH] = pat(i);
            chk(ack, "R3 data ack", ack, 1);
        end
        bus_stop();

        // R7: addressable immediately after the write STOP
        bus_start();
        send_byte(devb(strap, 1'b0), ack);
        chk(ack, "R7 ack after write stop", ack, 1);
        bus_stop();

        // R5/R4: sequential read past the array end
        read_check(8'h7F, 8'h45, 70, "R5 R4 sequential read");

        // R9: current address = (5 + 70) mod 64 = 11
        bus_start();
        send_byte(devb(strap, 1'b1), ack);
        chk(ack, "R9 read device ack", ack, 1);
        recv_byte(1'b0, got);
        chk(got == exp_mem[11], "R9 current address read", got, exp_mem[11]);
        bus_stop();
        chk(sda_oe == 1'b0, "R5 released after NACK", sda_oe, 0);

        // R6: protected write acked but not stored, read while protected
        wp = 1'b1;
        bus_start();
        send_byte(devb(strap, 1'b0), ack);
        send_byte(8'h00, ack);
        send_byte(8'h10, ack);
        for (int i = 0; i < 3; i++) begin
            send_byte(~exp_mem[16 + i], ack);
            chk(ack, "R6 protected data ack", ack, 1);
        end
        bus_stop();
        read_check(8'h00, 8'h10, 3, "R6 protected unchanged");
        wp = 1'b0;

        // R2: mismatched device, following bytes must not write
        bus_start();
        send_byte(devb(3'b010, 1'b0), ack);
        chk(!ack, "R2 mismatch nack", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R2 ignored after mismatch", ack, 0);
        send_byte(8'h20, ack);
        send_byte(~exp_mem[32], ack);
        bus_stop();
        read_check(8'h00, 8'h20, 1, "R2 no leak after mismatch");

        chk(r8_bad == 0, "R8 oe stable while SCL high", r8_bad, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule